// File: doc/BRIEF.md
# UART Interrupt and Receive-Timeout Controller

This block gathers the interrupt causes of a serial port into one request line. Four causes arrive as single-cycle strobes from the neighbouring logic: receive FIFO reached its level, transmit FIFO reached its level, a framing error, and a parity error. A fifth cause, receive timeout, is made inside the block. An idle counter advances once per bit period while the receive FIFO holds data. It fires when no new character has arrived for a set number of bit periods.

Every cause latches into a raw status bit whether or not it is enabled, so polling software can always see it. A mask register chooses which causes reach the request line. The masked status is the raw status gated by the mask. The request line is the OR of the masked bits, so one service pass can read every pending cause. Software clears causes by writing ones to a clear register. The timeout cause also clears by itself when the receive FIFO drains.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the raw status and the mask are all zero and `irqOut` is low.
- R2: Status bit positions are: bit 0 receive level, bit 1 transmit level, bit 2 receive timeout, bit 3 framing error, bit 4 parity error. A strobe on `rxLevelEvt`, `txLevelEvt`, `framingErrEvt` or `parityErrEvt` sets its raw bit at the next clock edge, whatever the mask holds.
- R3: A write with `regWrEn`=1 and `regSel`=0 loads `regWrData` into the mask at the next edge.
- R4: `maskedStatus` is the raw status ANDed with the mask, and `irqOut` is high exactly when any masked bit is set.
- R5: A write with `regWrEn`=1 and `regSel`=1 clears, at the next edge, each raw bit whose data bit is 1. Data bits of 0 leave their raw bits unchanged.
- R6: When an event strobe and a clear write for the same bit fall in the same cycle, the bit ends up set.
- R7: With the receive FIFO non-empty, the timeout bit sets at the edge that ends the IDLE_LIMIT-th `bitTick` cycle after the last `rxCharStrobe`, and not one tick earlier.
- R8: An `rxCharStrobe` restarts the idle count from zero.
- R9: Once the timeout has fired, further ticks do not fire it again until a new character arrives or the FIFO empties.
- R10: While `rxFifoEmpty` is high the idle count stays at zero and the timeout bit clears at the next edge. Ticks while the FIFO is empty never fire the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle enable, once per bit period |
| rxCharStrobe | input | 1 | A character was written into the receive FIFO |
| rxFifoEmpty | input | 1 | Receive FIFO is empty |
| rxLevelEvt | input | 1 | Receive FIFO level strobe |
| txLevelEvt | input | 1 | Transmit FIFO level strobe |
| framingErrEvt | input | 1 | Framing error strobe |
| parityErrEvt | input | 1 | Parity error strobe |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Write target: 0 mask, 1 clear |
| regWrData | input | 5 | Write data, one bit per cause |
| rawStatus | output | 5 | Raw status |
| maskReg | output | 5 | Current mask |
| maskedStatus | output | 5 | Raw status AND mask |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The receive timeout is the hardest cause to reach from the ports. It needs a non-empty FIFO, a character strobe to start the window, and then an exact count of bit ticks. The bench drives the tick count to one below the limit and checks that nothing has fired, then gives one more tick and checks that the bit sets. It then restarts the window partway through, runs far past the limit to show the timeout does not fire again, and drains and refills the FIFO to re-arm it. The mask and clear paths are swept over every mask value and every clear pattern.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int BIT_RXLVL = 0;
  localparam int BIT_TXLVL = 1;
  localparam int BIT_RXTO  = 2;
  localparam int BIT_FRAME = 3;
  localparam int BIT_PAR   = 4;

  // strobes from timeout control to the status datapath
  typedef struct packed {
    logic toFire;    // idle window expired this cycle
    logic drained;   // receive FIFO currently empty
  } ctlStrobes_t;
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
#(
  parameter int IDLE_LIMIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bitTick,
  input  logic        rxCharStrobe,
  input  logic        rxFifoEmpty,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);

  logic [CNT_W-1:0] idleCnt;
  logic             fired;
  logic             countEn;
  logic             atLast;

  // count only when data waits, no new char, one bit period elapsed, not yet fired
  assign countEn = !rxFifoEmpty && !rxCharStrobe && bitTick && !fired;
  assign atLast  = (idleCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idleCnt <= '0;
      fired   <= 1'b0;
    end else if (rxFifoEmpty || rxCharStrobe) begin
      idleCnt <= '0;
      fired   <= 1'b0;
    end else if (countEn) begin
      if (atLast) begin
        idleCnt <= '0;
        fired   <= 1'b1;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.toFire  = countEn && atLast;
    strobes.drained = rxFifoEmpty;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        strobes,
  input  logic               rxLevelEvt,
  input  logic               txLevelEvt,
  input  logic               framingErrEvt,
  input  logic               parityErrEvt,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] rawNext;

  always_comb begin
    setVec            = '0;
    setVec[BIT_RXLVL] = rxLevelEvt;
    setVec[BIT_TXLVL] = txLevelEvt;
    setVec[BIT_RXTO]  = strobes.toFire;
    setVec[BIT_FRAME] = framingErrEvt;
    setVec[BIT_PAR]   = parityErrEvt;

    clrVec = (regWrEn && regSel) ? regWrData : '0;
    clrVec[BIT_RXTO] = clrVec[BIT_RXTO] | strobes.drained;
  end

  // set beats clear so a coincident event is kept
  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      assign rawNext[i] = setVec[i] | (rawStatus[i] & ~clrVec[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rawStatus <= '0;
      maskReg   <= '0;
    end else begin
      rawStatus <= rawNext;
      if (regWrEn && !regSel) maskReg <= regWrData;
    end
  end

  assign maskedStatus = rawStatus & maskReg;
  assign irqOut       = |maskedStatus;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int IDLE_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitTick,
  input  logic       rxCharStrobe,
  input  logic       rxFifoEmpty,
  input  logic       rxLevelEvt,
  input  logic       txLevelEvt,
  input  logic       framingErrEvt,
  input  logic       parityErrEvt,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [4:0] regWrData,
  output logic [4:0] rawStatus,
  output logic [4:0] maskReg,
  output logic [4:0] maskedStatus,
  output logic       irqOut
);
  ctlStrobes_t strobes;

  uart_irq_ctl #(.IDLE_LIMIT(IDLE_LIMIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bitTick(bitTick),
    .rxCharStrobe(rxCharStrobe), .rxFifoEmpty(rxFifoEmpty),
    .strobes(strobes)
  );

  uart_irq_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .rxLevelEvt(rxLevelEvt), .txLevelEvt(txLevelEvt),
    .framingErrEvt(framingErrEvt), .parityErrEvt(parityErrEvt),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .rawStatus(rawStatus), .maskReg(maskReg),
    .maskedStatus(maskedStatus), .irqOut(irqOut)
  );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bitTick,
  input logic       rxCharStrobe,
  input logic       rxFifoEmpty,
  input logic       rxLevelEvt,
  input logic       txLevelEvt,
  input logic       framingErrEvt,
  input logic       parityErrEvt,
  input logic       regWrEn,
  input logic       regSel,
  input logic [4:0] regWrData,
  input logic [4:0] rawStatus,
  input logic [4:0] maskReg,
  input logic [4:0] maskedStatus,
  input logic       irqOut
);
  assert_parity_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    parityErrEvt |=> rawStatus[4]);

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regSel) |=> (maskReg == $past(regWrData)));

  assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> ((rawStatus & maskReg) != 5'd0));

  assert_clear_rxlvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regSel && regWrData[0] && !rxLevelEvt) |=> !rawStatus[0]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (framingErrEvt && regWrEn && regSel && regWrData[3]) |=> rawStatus[3]);

  assert_drain_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rxFifoEmpty |=> !rawStatus[2]);

  assert_timeout_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rawStatus[2]) |-> (!$past(rxFifoEmpty) && $past(bitTick)));
endmodule

bind uart_irq_ctrl uart_irq_chk u_chk (.*);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitTick = 0, rxCharStrobe = 0, rxFifoEmpty = 1;
  logic rxLevelEvt = 0, txLevelEvt = 0, framingErrEvt = 0, parityErrEvt = 0;
  logic regWrEn = 0, regSel = 0;
  logic [4:0] regWrData = '0;
  logic [4:0] rawStatus, maskReg, maskedStatus;
  logic irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.IDLE_LIMIT(32)) u0 (.*);

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    bitTick = 0; rxCharStrobe = 0; rxLevelEvt = 0; txLevelEvt = 0;
    framingErrEvt = 0; parityErrEvt = 0; regWrEn = 0; regSel = 0; regWrData = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic sel, input logic [4:0] d);
    regWrEn = 1; regSel = sel; regWrData = d;
    cyc();
  endtask

  task automatic events(input logic [4:0] p);
    rxLevelEvt = p[0]; txLevelEvt = p[1]; framingErrEvt = p[3]; parityErrEvt = p[4];
    cyc();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bitTick = 1;
      cyc();
    end
  endtask

  task automatic newChar();
    rxCharStrobe = 1; rxFifoEmpty = 0;
    cyc();
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 raw", rawStatus, 5'd0);
    chk("R1 mask", maskReg, 5'd0);
    chk("R1 irq", {4'd0, irqOut}, 5'd0);

    // R2 events latch with mask zero
    events(5'b11011);
    chk("R2 raw set unmasked", rawStatus, 5'b11011);
    chk("R2 irq masked off", {4'd0, irqOut}, 5'd0);

    // R5 clear sweep: write-one clears, zeros keep
    for (int c = 0; c < 32; c++) begin
      wr(1, 5'b11111);
      events(5'b11011);
      wr(1, 5'(c));
      chk("R5 clear pattern", rawStatus, 5'b11011 & ~5'(c));
    end

    // R3/R4 sweep over every mask and event pattern
    for (int m = 0; m < 32; m++) begin
      wr(0, 5'(m));
      chk("R3 mask load", maskReg, 5'(m));
      for (int e = 0; e < 16; e++) begin
        logic [4:0] pat;
        pat = {e[3], e[2], 1'b0, e[1], e[0]};
        wr(1, 5'b11111);
        events(pat);
        chk("R4 masked", maskedStatus, pat & 5'(m));
        chk("R4 irq", {4'd0, irqOut}, {4'd0, |(pat & 5'(m))});
      end
    end

    // R6 set wins over coincident clear
    wr(1, 5'b11111);
    regWrEn = 1; regSel = 1; regWrData = 5'b11011;
    framingErrEvt = 1; parityErrEvt = 1;
    cyc();
    chk("R6 set wins", rawStatus, 5'b11000);
    wr(1, 5'b11111);

    // R7 exact timeout boundary
    wr(0, 5'b00100);
    newChar();
    ticks(31);
    chk("R7 no fire at limit-1", rawStatus, 5'd0);
    ticks(1);
    chk("R7 fire at limit", rawStatus, 5'b00100);
    chk("R7 irq", {4'd0, irqOut}, 5'd1);

    // R9 no refire after clear
    wr(1, 5'b00100);
    chk("R9 cleared", rawStatus, 5'd0);
    ticks(80);
    chk("R9 no refire", rawStatus, 5'd0);

    // R8 restart by new character
    newChar();
    ticks(20);
    newChar();
    ticks(31);
    chk("R8 restarted no fire", rawStatus, 5'd0);
    ticks(1);
    chk("R8 restarted fire", rawStatus, 5'b00100);

    // R10 drain auto-clear and hold while empty
    rxFifoEmpty = 1;
    cyc();
    chk("R10 drain clears", rawStatus, 5'd0);
    ticks(70);
    chk("R10 empty no fire", rawStatus, 5'd0);
    newChar();
    ticks(31);
    chk("R10 refill no early fire", rawStatus, 5'd0);
    ticks(1);
    chk("R10 refill fires", rawStatus, 5'b00100);

    // R1 reset again clears everything
    rst_n = 0;
    cyc();
    rst_n = 1;
    chk("R1 reset raw", rawStatus, 5'd0);
    chk("R1 reset mask", maskReg, 5'd0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule